// File: doc/BRIEF.md
# Programmable-Length Serial Shift Register

This block is a one-bit serial delay line whose depth can be changed while it runs. A binary length code selects how many stages lie between the serial input and the output, from one stage up to `MAX_LEN` stages. Two serial data inputs are available. A select line picks one of them for each shift. Tying the second input to the block's own output turns the line into a recirculating loop that holds its contents.

Shifts are not taken on every system clock. Two shift-control inputs act as a pair, and each one gates the other. A shift occurs when the first control rises while the second is low. A shift also occurs when the second control falls while the first is high. Both controls are synchronised into the system clock domain, and edges are found by comparing successive samples.

An asynchronous master reset empties every stage at once. Its release is synchronised before shifting resumes. The block drives a true output and an inverted output, both taken from the last selected stage.

Top module: `varlen_shreg`

## Requirements
- R1: Length code `len_sel` (bit i has weight 2^i) gives a line of `len_sel`+1 stages. The output equals the bit that was applied on the `len_sel`+1-th most recent shift, or 0 if fewer shifts have occurred since reset.
- R2: A code of all zeros gives a 1-stage line: a bit appears at the output after one shift. A code of all ones gives a line of `MAX_LEN` stages.
- R3: When `src_sel` is 0, each shift takes its bit from `din_a`. When `src_sel` is 1, it takes the bit from `din_b`. With `din_b` tied to `q`, the contents recirculate unchanged.
- R4: A rising edge on `trig_up` while `trig_dn` is low causes exactly one shift. A falling edge on `trig_up` causes no shift.
- R5: A falling edge on `trig_dn` while `trig_up` is high causes exactly one shift. A falling edge on `trig_dn` while `trig_up` is low causes no shift. A rising edge on `trig_up` while `trig_dn` is high causes no shift.
- R6: While `rst_in` is high, all stages are zero, `q` is 0 and `q_n` is 1, with no clock edge needed and whatever the other inputs are.
- R7: `q_n` is always the inverse of `q`.
- R8: Changing `len_sel` moves no stored data. The output at once shows the stage at the new depth.
- R9: While neither control input changes, the stored data stays fixed.
- R10: Control levels held through reset cause no shift when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_in | input | 1 | Asynchronous master reset, active high |
| len_sel | input | $clog2(MAX_LEN) | Binary length code; length = value + 1 |
| src_sel | input | 1 | Serial source select: 0 = din_a, 1 = din_b |
| din_a | input | 1 | Serial data input A |
| din_b | input | 1 | Serial data input B |
| trig_up | input | 1 | Shift control; its rising edge shifts while trig_dn is low |
| trig_dn | input | 1 | Shift control; its falling edge shifts while trig_up is high |
| q | output | 1 | Selected final stage |
| q_n | output | 1 | Inverse of q |

## Verification
The bench builds the block with `MAX_LEN` = 16, which makes a four-bit length code. At that size every length from one to the maximum is driven with a pseudo-random bit stream. Shifts alternate between the two trigger styles and the data source is switched at random. After stimulus, the whole line is read back by sweeping the length code across every depth. This reveals each stored bit. It exposes any stray or missing shift, including after reset release, after static periods and after gated edges.

// File: rtl/varlen_shreg.sv
module varlen_shreg #(
  parameter int MAX_LEN     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_in,
  input  logic [$clog2(MAX_LEN)-1:0] len_sel,
  input  logic                       src_sel,
  input  logic                       din_a,
  input  logic                       din_b,
  input  logic                       trig_up,
  input  logic                       trig_dn,
  output logic                       q,
  output logic                       q_n
);
  localparam int RUN_DEPTH = SYNC_STAGES + 1;

  logic [SYNC_STAGES-1:0] up_sync, dn_sync;
  logic                   up_prev, dn_prev;
  logic [RUN_DEPTH-1:0]   run_sync;
  logic [MAX_LEN-1:0]     stages;
  logic                   up_s, dn_s, run, ser_in, rise_ev, fall_ev, shift_ev;

  always_ff @(posedge clk or posedge rst_in) begin
    if (rst_in) begin
      up_sync  <= '0;
      dn_sync  <= '0;
      up_prev  <= 1'b0;
      dn_prev  <= 1'b0;
      run_sync <= '0;
    end else begin
      up_sync  <= {up_sync[SYNC_STAGES-2:0], trig_up};
      dn_sync  <= {dn_sync[SYNC_STAGES-2:0], trig_dn};
      up_prev  <= up_s;
      dn_prev  <= dn_s;
      run_sync <= {run_sync[RUN_DEPTH-2:0], 1'b1};
    end
  end

  assign up_s     = up_sync[SYNC_STAGES-1];
  assign dn_s     = dn_sync[SYNC_STAGES-1];
  assign run      = run_sync[RUN_DEPTH-1];
  assign rise_ev  = up_s & ~up_prev & ~dn_s;
  assign fall_ev  = dn_prev & ~dn_s & up_s;
  assign shift_ev = run & (rise_ev | fall_ev);
  assign ser_in   = src_sel ? din_b : din_a;

  always_ff @(posedge clk or posedge rst_in) begin
    if (rst_in)        stages <= '0;
    else if (shift_ev) stages <= {stages[MAX_LEN-2:0], ser_in};
  end

  assign q   = stages[len_sel];
  assign q_n = ~q;

  AST_SHIFT_ADVANCE: assert property (@(posedge clk) disable iff (rst_in)
    shift_ev |=> (stages[MAX_LEN-1:1] == $past(stages[MAX_LEN-2:0])) && (stages[0] == $past(ser_in))); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst_in)
    !shift_ev |=> $stable(stages)); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    (rst_in && $past(rst_in)) |-> (stages == '0 && !q && q_n)); // R6
  AST_NO_SHIFT_IN_RELEASE: assert property (@(posedge clk) disable iff (rst_in)
    !run |=> $stable(stages)); // R10
endmodule

// File: tb/varlen_shreg_tb.sv
module varlen_shreg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXL = 16;
  localparam int LW = $clog2(MAXL);

  logic clk = 1'b0;
  logic rst_in = 1'b1;
  logic [LW-1:0] len_sel = '0;
  logic src_sel = 1'b0, din_a = 1'b0, b_drv = 1'b0, recirc = 1'b0;
  logic trig_up = 1'b0, trig_dn = 1'b0;
  logic q, q_n;
  wire  din_b = recirc ? q : b_drv;

  logic [MAXL-1:0] hist = '0;
  logic [15:0] lfsr = 16'hACE1;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  varlen_shreg #(.MAX_LEN(MAXL), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_in(rst_in), .len_sel(len_sel), .src_sel(src_sel),
    .din_a(din_a), .din_b(din_b), .trig_up(trig_up), .trig_dn(trig_dn),
    .q(q), .q_n(q_n));

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b time=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic do_reset();
    rst_in = 1'b1; hist = '0;
    cyc(2);
    rst_in = 1'b0;
    cyc(5);
  endtask

  task automatic push(input logic b, input bit via_dn);
    if (!recirc) begin
      if (src_sel) begin b_drv = b; din_a = ~b; end
      else begin din_a = b; b_drv = ~b; end
    end
    hist = {hist[MAXL-2:0], b};
    if (!via_dn) begin
      trig_dn = 1'b0; trig_up = 1'b1; cyc(4);
      trig_up = 1'b0; cyc(4);
    end else begin
      trig_dn = 1'b1; cyc(4);
      trig_up = 1'b1; cyc(4);
      trig_dn = 1'b0; cyc(4);
      trig_up = 1'b0; cyc(4);
    end
  endtask

  task automatic sweep(input string req);
    logic [LW-1:0] keep;
    keep = len_sel;
    for (int l = 0; l < MAXL; l++) begin
      len_sel = LW'(l); #1;
      chk(req, q, hist[l]);
    end
    len_sel = keep; #1;
  endtask

  initial begin
    cyc(3);
    chk("R6 reset q", q, 1'b0);
    chk("R7 reset q_n", q_n, 1'b1);
    rst_in = 1'b0; cyc(5);

    for (int L = 1; L <= MAXL; L++) begin
      do_reset();
      len_sel = LW'(L - 1);
      for (int k = 0; k < L + 6; k++) begin
        logic b;
        bit dn;
        b = rnd();
        src_sel = rnd();
        dn = (k % 2) == 1;
        push(b, dn);
        if (L == 1 || L == MAXL) chk("R2 length end", q, hist[len_sel]);
        if (dn) chk("R1 R3 R5 fall shift", q, hist[len_sel]);
        else    chk("R1 R3 R4 rise shift", q, hist[len_sel]);
        chk("R7 complement", q_n, ~q);
      end
    end

    sweep("R8 length change");

    cyc(20);
    sweep("R9 static");

    trig_dn = 1'b1; cyc(4);
    trig_dn = 1'b0; cyc(4);
    sweep("R5 gated fall");
    trig_dn = 1'b1; cyc(4);
    trig_up = 1'b1; cyc(4);
    sweep("R5 gated rise");
    trig_up = 1'b0; cyc(4);
    sweep("R4 up fall");
    trig_dn = 1'b0; cyc(4);

    rst_in = 1'b1; hist = '0;
    trig_up = 1'b1; trig_dn = 1'b0; src_sel = 1'b0; din_a = 1'b1;
    cyc(2);
    rst_in = 1'b0; cyc(10);
    sweep("R10 release");
    trig_up = 1'b0; cyc(4);
    sweep("R10 after");

    do_reset();
    len_sel = '0;
    push(1'b1, 1'b0);
    chk("R2 one stage", q, 1'b1);

    len_sel = LW'(MAXL - 1);
    for (int k = 0; k < MAXL; k++) push(1'b1, 1'b0);
    chk("R2 full ones", q, 1'b1);
    #2 rst_in = 1'b1; #1;
    chk("R6 async q", q, 1'b0);
    chk("R6 async q_n", q_n, 1'b1);
    hist = '0;
    cyc(2);
    sweep("R6 cleared");
    rst_in = 1'b0; cyc(5);

    len_sel = LW'(4);
    src_sel = 1'b0;
    push(1'b1, 1'b0); push(1'b0, 1'b1); push(1'b1, 1'b0);
    push(1'b1, 1'b1); push(1'b0, 1'b0);
    recirc = 1'b1; src_sel = 1'b1;
    for (int k = 0; k < 10; k++) begin
      push(hist[4], k % 2 == 1);
      chk("R3 recirculate", q, hist[4]);
    end
    sweep("R3 recirc contents");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R9 actual=timeout expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule